// File: doc/BRIEF.md
# Bank GPIO Controller with Pin Interrupt Detection

This block controls a bank of general-purpose pins (32 by default). Each pin owns a control word on a simple word-addressed register bus that holds its direction, output buffer type, output level, function selection, input gating and interrupt detect mode. Two bank-wide words complete the pin map: a parallel input word that returns every pin's sampled level, and a parallel output word that can take over the output level of any pin that hands it ownership.

Each pin either runs as a plain GPIO or passes one of seven alternate functions through to the pad. An optional inversion sits between an alternate function and the pad, in both directions. Pad inputs are synchronised through two flops. They can be gated low by an input-off bit or by the power-off code of the power select field. The gated level feeds the readback, the parallel input word and an interrupt detector. The detector reports level-low, level-high, rising, falling or both-edge conditions into a sticky status word. Software clears that word by writing ones to it. The status word, masked by an enable word, drives one bank interrupt line. Pull, power domain and other analog selections are stored and read back only.

Top module: `gpio_bank`

## Requirements
- R1: After reset every control word reads 0x0000_0040 (detect mode field [7:4] = 4, all else 0). The parallel output, status and enable words read 0. `pad_oe` is all zeros and `irq` is 0.
- R2: In GPIO function (field [14:12] = 0) with direction bit 9 = 1, the pin level is control bit 16 when the ownership bit 10 is 0. It is the pin's bit of the parallel output word (address NPINS+1) when bit 10 is 1, and bit 16 then has no effect on `pad_out`.
- R3: In GPIO function, direction bit 9 = 0 keeps `pad_oe` low for that pin.
- R4: With buffer type bit 8 = 1 (open drain), a level of 1 deasserts `pad_oe` and a level of 0 drives low. With bit 8 = 0 both levels are driven.
- R5: A function field value f in 1..7 drives `pad_out` from `alt_do[(f-1)*NPINS+pin]`, XORed with inversion bit 11, and `pad_oe` from `alt_oe[(f-1)*NPINS+pin]`. The direction bit is ignored.
- R6: `alt_di` for a pin is its gated input level XORed with inversion bit 11.
- R7: Input-off bit 15 = 1 or power select field [3:2] = 2 forces the gated input to 0 in readback bit 24, in the parallel input word (address NPINS) and in detection. Power select 2 also holds `pad_oe` low.
- R8: A change on `pad_in` reaches readback bit 24 and the parallel input word after exactly two rising clock edges.
- R9: Detect code 0 sets status while the gated input is low. Code 1 sets it while the gated input is high.
- R10: Detect codes 13, 14 and 15 set status on a rising edge, a falling edge and either edge of the gated input. This includes a pulse on `pad_in` lasting one clock cycle.
- R11: Detect code 4 and the unused codes 2, 3 and 5..12 never set status.
- R12: Status bits (address NPINS+2) hold until a write with a 1 in that bit position clears them. A detect condition in the same cycle wins over the clear, and zeros in the written data leave bits untouched.
- R13: `irq` is high exactly when some status bit and its bit in the enable word (address NPINS+3) are both 1.
- R14: Control word bits 31:17 ignore writes. Bits 31:25 and 23:17 read 0, and bit 24 always reads the gated pad level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | Write qualifier for the strobe |
| bus_addr | input | AW | Word address: pins 0..NPINS-1, then parallel in, parallel out, status, enable |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| pad_in | input | NPINS | Asynchronous pad levels |
| pad_out | output | NPINS | Pad output levels |
| pad_oe | output | NPINS | Pad driver enables |
| alt_do | input | 7*NPINS | Alternate function output levels, function-major |
| alt_oe | input | 7*NPINS | Alternate function driver enables, function-major |
| alt_di | output | NPINS | Gated, optionally inverted input for alternate functions |
| irq | output | 1 | Bank interrupt |

## Verification
A register write takes effect at the clock edge that ends it. Pad output and enable are combinational from the registers, so the bench checks them at the falling edge right after the write. Pad inputs appear in readback after two rising edges and set status on the third, and `irq` follows status with no extra cycle. The bench therefore checks the two-edge latency at the exact cycle, and otherwise waits a fixed settle time longer than these latencies before it reads a result. For interrupt checks it clears status only once the input has been stable for four cycles, so no earlier transition leaks into the result.

// File: rtl/gpio_bank_pkg.sv
// Package: shared types, field layout and detect decoding for the GPIO bank.
// Assumes the control word keeps its behavioural fields in bits 16:0.
package gpio_bank_pkg;

    localparam int NALT   = 7;
    localparam int WORD_W = 32;
    localparam int CFG_W  = 17;

    // Power select codes (only OFF has modelled behaviour).
    localparam logic [1:0] PWR_OFF = 2'd2;

    // Interrupt detect codes; every other value behaves as DET_OFF.
    typedef enum logic [3:0] {
        DET_LOW  = 4'd0,
        DET_HIGH = 4'd1,
        DET_OFF  = 4'd4,
        DET_RISE = 4'd13,
        DET_FALL = 4'd14,
        DET_BOTH = 4'd15
    } det_mode_e;

    // Stored writable part of a control word, bit 16 down to bit 0.
    typedef struct packed {
        logic       out_val;   // 16
        logic       in_off;    // 15
        logic [2:0] fsel;      // 14:12
        logic       alt_inv;   // 11
        logic       par_own;   // 10
        logic       drv_dir;   // 9
        logic       open_drn;  // 8
        logic [3:0] irq_mode;  // 7:4
        logic [1:0] pwr_sel;   // 3:2
        logic [1:0] pull_sel;  // 1:0
    } pin_cfg_t;

    // Behavioural controls handed from the register file to a pin slice.
    typedef struct packed {
        logic       out_val;
        logic       in_off;
        logic       pwr_off;
        logic [2:0] fsel;
        logic       alt_inv;
        logic       par_own;
        logic       drv_dir;
        logic       open_drn;
        logic [3:0] irq_mode;
    } pin_ctl_t;

    localparam pin_cfg_t CFG_RST = '{irq_mode: DET_OFF, default: '0};

    // Returns 1 when the detect mode fires for the current and previous level.
    function automatic logic det_fire(input logic [3:0] mode, input logic cur,
                                      input logic prv);
        case (mode)
            DET_LOW:  return !cur;
            DET_HIGH: return cur;
            DET_RISE: return cur && !prv;
            DET_FALL: return !cur && prv;
            DET_BOTH: return cur ^ prv;
            default:  return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/gpio_sync.sv
// Module: two-flop synchroniser for a vector of asynchronous inputs.
// Assumes each bit is sampled independently; no bus coherency is implied.
module gpio_sync #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] q_sync
);

    logic [W-1:0] meta_q;
    logic [W-1:0] sync_q;

    // Two-stage capture with synchronous clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
        end else begin
            meta_q <= d_async;
            sync_q <= meta_q;
        end
    end

    assign q_sync = sync_q;

endmodule

// File: rtl/gpio_regs.sv
// Module: register file for the GPIO bank. Holds per-pin control words,
// the parallel output word, sticky status and interrupt enable.
// Assumes 2 <= NPINS <= 32; reads are combinational, writes land on the edge.
module gpio_regs
    import gpio_bank_pkg::*;
#(
    parameter int NPINS = 32,
    parameter int AW    = $clog2(NPINS + 4)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bus_sel,
    input  logic                  bus_wr,
    input  logic [AW-1:0]         bus_addr,
    input  logic [WORD_W-1:0]     bus_wdata,
    output logic [WORD_W-1:0]     bus_rdata,
    input  logic [NPINS-1:0]      in_level,
    input  logic [NPINS-1:0]      det_hit,
    output pin_ctl_t [NPINS-1:0]  ctl_o,
    output logic [NPINS-1:0]      par_out_o,
    output logic [NPINS-1:0]      status_o,
    output logic [NPINS-1:0]      inten_o
);

    localparam int           IW        = $clog2(NPINS);
    localparam logic [AW-1:0] A_PAR_IN  = AW'(NPINS);
    localparam logic [AW-1:0] A_PAR_OUT = AW'(NPINS + 1);
    localparam logic [AW-1:0] A_STATUS  = AW'(NPINS + 2);
    localparam logic [AW-1:0] A_ENABLE  = AW'(NPINS + 3);

    pin_cfg_t [NPINS-1:0] cfg_q;
    logic [NPINS-1:0]     par_out_q;
    logic [NPINS-1:0]     status_q;
    logic [NPINS-1:0]     inten_q;
    logic                 wr_en;
    logic [NPINS-1:0]     clr_mask;
    logic [IW-1:0]        pin_idx;

    assign wr_en   = bus_sel && bus_wr;
    assign pin_idx = bus_addr[IW-1:0];

    // Per-pin control words: masked write, reset to the disabled detect code.
    always_ff @(posedge clk) begin
        for (int i = 0; i < NPINS; i++) begin
            if (!rst_n)
                cfg_q[i] <= CFG_RST;
            else if (wr_en && bus_addr == AW'(i))
                cfg_q[i] <= pin_cfg_t'(bus_wdata[CFG_W-1:0]);
        end
    end

    // Bank-wide parallel output and interrupt enable words.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            par_out_q <= '0;
            inten_q   <= '0;
        end else if (wr_en) begin
            if (bus_addr == A_PAR_OUT) par_out_q <= bus_wdata[NPINS-1:0];
            if (bus_addr == A_ENABLE)  inten_q   <= bus_wdata[NPINS-1:0];
        end
    end

    // Write-one-to-clear mask for the status word.
    always_comb begin
        clr_mask = '0;
        if (wr_en && bus_addr == A_STATUS) clr_mask = bus_wdata[NPINS-1:0];
    end

    // Sticky status: new detections take priority over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n) status_q <= '0;
        else        status_q <= (status_q & ~clr_mask) | det_hit;
    end

    // Read mux; control words return the live gated pad level in bit 24.
    always_comb begin
        bus_rdata = '0;
        if (bus_addr < A_PAR_IN) begin
            bus_rdata[CFG_W-1:0] = cfg_q[pin_idx];
            bus_rdata[24]        = in_level[pin_idx];
        end else begin
            case (bus_addr)
                A_PAR_IN:  bus_rdata = WORD_W'(in_level);
                A_PAR_OUT: bus_rdata = WORD_W'(par_out_q);
                A_STATUS:  bus_rdata = WORD_W'(status_q);
                A_ENABLE:  bus_rdata = WORD_W'(inten_q);
                default:   bus_rdata = '0;
            endcase
        end
    end

    // Hand the behavioural subset of each control word to its pin slice.
    always_comb begin
        for (int i = 0; i < NPINS; i++) begin
            ctl_o[i].out_val  = cfg_q[i].out_val;
            ctl_o[i].in_off   = cfg_q[i].in_off;
            ctl_o[i].pwr_off  = (cfg_q[i].pwr_sel == PWR_OFF);
            ctl_o[i].fsel     = cfg_q[i].fsel;
            ctl_o[i].alt_inv  = cfg_q[i].alt_inv;
            ctl_o[i].par_own  = cfg_q[i].par_own;
            ctl_o[i].drv_dir  = cfg_q[i].drv_dir;
            ctl_o[i].open_drn = cfg_q[i].open_drn;
            ctl_o[i].irq_mode = cfg_q[i].irq_mode;
        end
    end

    assign par_out_o = par_out_q;
    assign status_o  = status_q;
    assign inten_o   = inten_q;

endmodule

// File: rtl/gpio_pin.sv
// Module: one pin slice. Selects GPIO or alternate drive, applies open-drain
// and power-off, gates the synchronised input and evaluates the detect mode.
// Assumes pad_sync is already synchronised to clk.
module gpio_pin
    import gpio_bank_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  pin_ctl_t        ctl,
    input  logic            par_bit,
    input  logic [NALT-1:0] alt_do,
    input  logic [NALT-1:0] alt_oe,
    input  logic            pad_sync,
    output logic            pad_out,
    output logic            pad_oe,
    output logic            in_level,
    output logic            alt_di,
    output logic            det_hit
);

    logic [NALT:0] do_tab;
    logic [NALT:0] oe_tab;
    logic          gpio_lvl;
    logic          drv_val;
    logic          drv_en;
    logic          prev_q;

    // Slot 0 of each table is the GPIO source, slots 1..7 the alternates.
    assign gpio_lvl = ctl.par_own ? par_bit : ctl.out_val;
    assign do_tab   = {alt_do, gpio_lvl};
    assign oe_tab   = {alt_oe, ctl.drv_dir};

    // Output selection, polarity, open-drain release and power-off gating.
    always_comb begin
        drv_val = do_tab[ctl.fsel];
        drv_en  = oe_tab[ctl.fsel];
        if (ctl.fsel != 3'd0) drv_val = drv_val ^ ctl.alt_inv;
        if (ctl.open_drn && drv_val) drv_en = 1'b0;
        if (ctl.pwr_off) drv_en = 1'b0;
    end

    assign pad_out  = drv_val;
    assign pad_oe   = drv_en;
    assign in_level = pad_sync && !ctl.in_off && !ctl.pwr_off;
    assign alt_di   = in_level ^ ctl.alt_inv;

    // Previous gated level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= in_level;
    end

    assign det_hit = det_fire(ctl.irq_mode, in_level, prev_q);

endmodule

// File: rtl/gpio_bank.sv
// Module: top of the GPIO bank. Wires the synchroniser, register file and one
// pin slice per pin; ORs enabled status into a single interrupt.
// Assumes 2 <= NPINS <= 32 and alternate vectors ordered function-major.
module gpio_bank
    import gpio_bank_pkg::*;
#(
    parameter int  NPINS = 32,
    localparam int AW    = $clog2(NPINS + 4)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bus_sel,
    input  logic                  bus_wr,
    input  logic [AW-1:0]         bus_addr,
    input  logic [31:0]           bus_wdata,
    output logic [31:0]           bus_rdata,
    input  logic [NPINS-1:0]      pad_in,
    output logic [NPINS-1:0]      pad_out,
    output logic [NPINS-1:0]      pad_oe,
    input  logic [NALT*NPINS-1:0] alt_do,
    input  logic [NALT*NPINS-1:0] alt_oe,
    output logic [NPINS-1:0]      alt_di,
    output logic                  irq
);

    pin_ctl_t [NPINS-1:0] pin_ctl;
    logic [NPINS-1:0]     par_out_q;
    logic [NPINS-1:0]     status_q;
    logic [NPINS-1:0]     inten_q;
    logic [NPINS-1:0]     pad_sync;
    logic [NPINS-1:0]     in_level;
    logic [NPINS-1:0]     det_hit;

    gpio_sync #(.W(NPINS)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (pad_in),
        .q_sync  (pad_sync)
    );

    gpio_regs #(.NPINS(NPINS), .AW(AW)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .in_level  (in_level),
        .det_hit   (det_hit),
        .ctl_o     (pin_ctl),
        .par_out_o (par_out_q),
        .status_o  (status_q),
        .inten_o   (inten_q)
    );

    for (genvar i = 0; i < NPINS; i++) begin : g_pin
        logic [NALT-1:0] pin_do;
        logic [NALT-1:0] pin_oe;

        // Gather this pin's bit from each alternate function vector.
        for (genvar f = 0; f < NALT; f++) begin : g_alt
            assign pin_do[f] = alt_do[f*NPINS + i];
            assign pin_oe[f] = alt_oe[f*NPINS + i];
        end

        gpio_pin u_pin (
            .clk      (clk),
            .rst_n    (rst_n),
            .ctl      (pin_ctl[i]),
            .par_bit  (par_out_q[i]),
            .alt_do   (pin_do),
            .alt_oe   (pin_oe),
            .pad_sync (pad_sync[i]),
            .pad_out  (pad_out[i]),
            .pad_oe   (pad_oe[i]),
            .in_level (in_level[i]),
            .alt_di   (alt_di[i]),
            .det_hit  (det_hit[i])
        );
    end

    assign irq = |(status_q & inten_q);

endmodule

// File: rtl/gpio_bank_chk.sv
// Module: assertion checker bound into gpio_bank.
// Assumes it sees the register file's control subset and status/enable words.
module gpio_bank_chk
    import gpio_bank_pkg::*;
#(
    parameter int NPINS = 32,
    parameter int AW    = $clog2(NPINS + 4)
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 bus_sel,
    input logic                 bus_wr,
    input logic [AW-1:0]        bus_addr,
    input logic [NPINS-1:0]     pad_oe,
    input logic                 irq,
    input pin_ctl_t [NPINS-1:0] ctl,
    input logic [NPINS-1:0]     status
);

    localparam logic [AW-1:0] A_STATUS = AW'(NPINS + 2);

    // R1
    rst_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (pad_oe == '0 && !irq));

    // R12
    status_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_sel && bus_wr && bus_addr == A_STATUS)
            |=> ((status & $past(status)) == $past(status)));

    for (genvar i = 0; i < NPINS; i++) begin : g_pin_chk
        // R3
        dir_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (ctl[i].fsel == 3'd0 && !ctl[i].drv_dir) |-> !pad_oe[i]);

        // R7
        pwr_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ctl[i].pwr_off |-> !pad_oe[i]);

        // R11
        det_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(status[i]) |->
                ($past(ctl[i].irq_mode) == DET_LOW  ||
                 $past(ctl[i].irq_mode) == DET_HIGH ||
                 $past(ctl[i].irq_mode) == DET_RISE ||
                 $past(ctl[i].irq_mode) == DET_FALL ||
                 $past(ctl[i].irq_mode) == DET_BOTH));
    end

endmodule

bind gpio_bank gpio_bank_chk #(.NPINS(NPINS), .AW(AW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_sel  (bus_sel),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .pad_oe   (pad_oe),
    .irq      (irq),
    .ctl      (pin_ctl),
    .status   (status_q)
);

// File: tb/gpio_bank_tb.sv
// Bench: sweeps a 4-pin bank over output, input and detect configurations,
// computing every expected value from the requirements.
module gpio_bank_tb;

    localparam int CLK_P = 10;
    localparam int N     = 4;
    localparam int AW    = 3;
    localparam int NA    = 7;
    localparam logic [AW-1:0] A_PIN_IN = 3'd4;
    localparam logic [AW-1:0] A_PAROUT = 3'd5;
    localparam logic [AW-1:0] A_STAT   = 3'd6;
    localparam logic [AW-1:0] A_EN     = 3'd7;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            bus_sel = 1'b0;
    logic            bus_wr = 1'b0;
    logic [AW-1:0]   bus_addr = '0;
    logic [31:0]     bus_wdata = '0;
    logic [31:0]     bus_rdata;
    logic [N-1:0]    pad_in = '0;
    logic [N-1:0]    pad_out;
    logic [N-1:0]    pad_oe;
    logic [NA*N-1:0] alt_do = '0;
    logic [NA*N-1:0] alt_oe = '0;
    logic [N-1:0]    alt_di;
    logic            irq;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    gpio_bank #(.NPINS(N)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pad_in    (pad_in),
        .pad_out   (pad_out),
        .pad_oe    (pad_oe),
        .alt_do    (alt_do),
        .alt_oe    (alt_oe),
        .alt_di    (alt_di),
        .irq       (irq)
    );

    always #(CLK_P/2) clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [31:0] ctl_word(input int dir, od, paren, pol, mux,
                                             val, pg, inpd, code);
        return 32'((dir << 9) | (od << 8) | (paren << 10) | (pol << 11) |
                   (mux << 12) | (val << 16) | (pg << 2) | (inpd << 15) | (code << 4));
    endfunction

    // Expected status after one detect phase (R9, R10, R11).
    function automatic logic exp_det(input int code, input int b, input int kind);
        logic lo, hi, rise, fall;
        lo   = (b == 0) || (kind != 1);
        hi   = (b == 1) || (kind != 1);
        rise = (b == 0 && kind != 1) || (b == 1 && kind == 2);
        fall = (b == 1 && kind != 1) || (b == 0 && kind == 2);
        case (code)
            0:  return lo;
            1:  return hi;
            13: return rise;
            14: return fall;
            15: return rise || fall;
            default: return 1'b0;
        endcase
    endfunction

    task automatic summary();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog (all requirements) actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        logic [31:0] rv;
        idle(3);
        rst_n = 1'b1;
        idle(1);

        // R1: reset state
        for (int p = 0; p < N; p++) begin
            rd(AW'(p), rv);
            chk("R1 ctrl reset", rv, 32'h40);
        end
        rd(A_PAROUT, rv); chk("R1 parout reset", rv, 0);
        rd(A_STAT, rv);   chk("R1 status reset", rv, 0);
        rd(A_EN, rv);     chk("R1 enable reset", rv, 0);
        chk("R1 pad_oe reset", 32'(pad_oe), 0);
        chk("R1 irq reset", 32'(irq), 0);

        // R2 R3 R4 R5: output configuration sweep on two pins
        for (int p = 0; p < N; p += 3) begin
            for (int c = 0; c < 512; c++) begin
                int dir, od, paren, val, par, pol, mux;
                logic ev, ee;
                logic [31:0] h1, h2;
                string tag;
                dir = c & 1; od = (c >> 1) & 1; paren = (c >> 2) & 1;
                val = (c >> 3) & 1; par = (c >> 4) & 1; pol = (c >> 5) & 1;
                mux = (c >> 6) & 7;
                h1 = 32'(c) * 32'h9E37_79B1;
                h2 = 32'(c) * 32'h85EB_CA6B;
                @(negedge clk);
                alt_do = h1[31:32-NA*N];
                alt_oe = h2[30:31-NA*N];
                wr(A_PAROUT, 32'(par << p));
                wr(AW'(p), ctl_word(dir, od, paren, pol, mux, val, 0, 0, 4));
                if (mux == 0) begin
                    ev = (paren != 0) ? par[0] : val[0];
                    ee = dir[0];
                end else begin
                    ev = alt_do[(mux-1)*N + p] ^ pol[0];
                    ee = alt_oe[(mux-1)*N + p];
                end
                if (od != 0 && ev) ee = 1'b0;
                tag = (mux != 0) ? "R5" : (od != 0) ? "R4" : (dir != 0) ? "R2" : "R3";
                chk({tag, " pad_out"}, 32'(pad_out[p]), 32'(ev));
                chk({tag, " pad_oe"}, 32'(pad_oe[p]), 32'(ee));
            end
        end

        // R7: power-off code holds the driver off even in output mode
        for (int mux = 0; mux < 8; mux++) begin
            alt_oe = '1;
            wr(3'd1, ctl_word(1, 0, 0, 0, mux, 0, 2, 0, 4));
            chk("R7 pwr off pad_oe", 32'(pad_oe[1]), 0);
        end
        alt_oe = '0;

        // R6 R7: input gating sweep
        for (int p = 0; p < N; p++) begin
            for (int c = 0; c < 32; c++) begin
                int inpd, pg, pv, pol;
                logic g;
                inpd = c & 1; pg = (c >> 1) & 3; pv = (c >> 3) & 1; pol = (c >> 4) & 1;
                wr(AW'(p), ctl_word(0, 0, 0, pol, 0, 0, pg, inpd, 4));
                pad_in = N'(pv << p);
                idle(3);
                g = (pv != 0) && (inpd == 0) && (pg != 2);
                rd(AW'(p), rv);
                chk("R7 ctrl readback", rv, ctl_word(0, 0, 0, pol, 0, 0, pg, inpd, 4) | (32'(g) << 24));
                rd(A_PIN_IN, rv);
                chk("R7 parallel in", rv, 32'(g) << p);
                chk("R6 alt_di", 32'(alt_di[p]), 32'(g ^ pol[0]));
            end
        end
        pad_in = '0;

        // R8: two-edge input latency
        wr(3'd1, 32'h40);
        idle(4);
        pad_in[1] = 1'b1;
        @(negedge clk);
        rd(A_PIN_IN, rv); chk("R8 after one edge", rv, 0);
        @(negedge clk);
        rd(A_PIN_IN, rv); chk("R8 after two edges", rv, 32'h2);
        pad_in = '0;
        idle(4);

        // R9 R10 R11: detect codes across six input phases on pin 2
        for (int code = 0; code < 16; code++) begin
            wr(3'd2, ctl_word(0, 0, 0, 0, 0, 0, 0, 0, code));
            for (int ph = 0; ph < 6; ph++) begin
                int b, kind;
                string tag;
                b = ph & 1; kind = ph >> 1;   // kind 0 step, 1 pulse, 2 hold
                kind = (kind == 0) ? 0 : (kind == 1) ? 2 : 1;
                @(negedge clk); pad_in[2] = b[0];
                idle(4);
                wr(A_STAT, 32'h4);
                if (kind != 1) pad_in[2] = ~b[0];
                if (kind == 2) begin
                    @(negedge clk); pad_in[2] = b[0];
                end
                idle(5);
                rd(A_STAT, rv);
                tag = (code <= 1) ? "R9" : (code >= 13) ? "R10" : "R11";
                chk({tag, " detect status"}, 32'(rv[2]), 32'(exp_det(code, b, kind)));
            end
        end
        wr(3'd2, 32'h40);
        pad_in = '0;
        idle(4);

        // R7: input-off blocks level-high detection
        wr(3'd2, ctl_word(0, 0, 0, 0, 0, 0, 0, 1, 1));
        pad_in[2] = 1'b1;
        idle(4);
        wr(A_STAT, 32'hF);
        idle(4);
        rd(A_STAT, rv); chk("R7 input off no detect", 32'(rv[2]), 0);
        wr(3'd2, 32'h40);
        pad_in = '0;
        idle(4);

        // R12: sticky hold, selective clear, set beats clear
        wr(A_STAT, 32'hF);
        wr(3'd0, ctl_word(0, 0, 0, 0, 0, 0, 0, 0, 13));
        @(negedge clk); pad_in[0] = 1'b1;
        idle(20);
        rd(A_STAT, rv); chk("R12 sticky hold", rv, 32'h1);
        wr(A_STAT, 32'h2);
        rd(A_STAT, rv); chk("R12 zero bits keep", rv, 32'h1);

        // R13: interrupt masking
        chk("R13 irq masked", 32'(irq), 0);
        wr(A_EN, 32'h2);
        chk("R13 other enable", 32'(irq), 0);
        wr(A_EN, 32'h1);
        chk("R13 irq enabled", 32'(irq), 1);
        wr(A_STAT, 32'h1);
        rd(A_STAT, rv); chk("R12 cleared", rv, 0);
        chk("R13 irq after clear", 32'(irq), 0);
        wr(3'd0, ctl_word(0, 0, 0, 0, 0, 0, 0, 0, 1));
        idle(2);
        wr(A_STAT, 32'h1);
        rd(A_STAT, rv); chk("R12 set beats clear", rv, 32'h1);
        wr(3'd0, 32'h40);
        wr(A_STAT, 32'hF);
        wr(A_EN, 32'h0);
        pad_in = '0;
        idle(4);

        // R14: upper control bits ignore writes
        wr(3'd1, 32'hFFFF_FFFF);
        rd(3'd1, rv); chk("R14 all ones write", rv, 32'h0001_FFFF);
        wr(3'd1, 32'h0100_0040);
        rd(3'd1, rv); chk("R14 bit24 write ignored", rv, 32'h40);
        pad_in[1] = 1'b1;
        idle(3);
        rd(3'd1, rv); chk("R14 bit24 follows pad", rv, 32'h0100_0040);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule